// File: doc/BRIEF.md
# Carry-Select Adder

A purely combinational adder that sums two unsigned operands and a carry-in. It produces a sum of the same width and a carry-out. The operand width is cut into equal groups of bits. The lowest group is a plain ripple chain fed by the external carry-in. Every group above it holds two ripple chains that work at the same time: one is tied to a carry-in of 0 and the other to a carry-in of 1. The carry leaving the group below only steers a multiplexer. That multiplexer hands on one of the two finished results, together with the matching carry-out, which in turn becomes the select for the next group up.

The worst-case path is one group's ripple plus one multiplexer per group above it. A full ripple across the whole width would be slower. The block fits wherever a wide add must settle within one clock period and there is area to spare for the duplicated chains. `WIDTH` must be a whole multiple of `GROUP`.

Top module: `csa_adder`

## Requirements
- R1: For every combination of `a`, `b` and `cin` at `WIDTH`=6 and `GROUP`=2, the 7-bit value {`cout`,`sum`} equals `a`+`b`+`cin`.
- R2: A carry entering at bit 0 travels through every group to `cout`: with `a` all ones, `b`=0 and `cin`=1, `sum` is 0 and `cout` is 1.
- R3: The lowest group adds the external carry-in directly: with `a`=`b`=0 and `cin`=1, `sum` is 1 and `cout` is 0.
- R4: In each upper group, the result of the chain tied to carry-in 1 is the result of the chain tied to carry-in 0 plus one, taking the group sum and its carry-out together. A carry crossing out of the lowest group (`a`=0x0000000F, `b`=1) gives `sum`=0x00000010.
- R5: When no carry enters an upper group, that group's sum bits equal the plain sum of its operand bits. Operands with no overlapping ones (0x12340000 + 0x00005678) give 0x12345678 with `cout`=0.
- R6: The carry selected at the top of each group equals the carry out of the exact prefix sum up to that bit. Its effect crosses two group boundaries: 0x000000FF + 1 gives 0x00000100.
- R7: Bitwise generate alone makes a carry: `a`=`b`=0x80000000 with `cin`=0 gives `sum`=0 and `cout`=1. All-zero inputs give all-zero outputs.
- R8: At `WIDTH`=32 and `GROUP`=4, {`cout`,`sum`} equals `a`+`b`+`cin` for random operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is a carry born at bit 0 that must pass through every multiplexer to the top. Random operands almost never propagate through all 32 bits. Directed vectors with all-ones operands force the full carry path, and other vectors place a carry exactly on one or two group boundaries. An exhaustive sweep of a 6-bit, 2-group-size instance covers every select pattern of the multiplexer chain. Random vectors then cover the wide instance.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // one-bit generate term
  function automatic logic pg_gen(input logic x, input logic y);
    return x & y;
  endfunction

  // one-bit propagate term
  function automatic logic pg_prop(input logic x, input logic y);
    return x ^ y;
  endfunction

  // sum bit from propagate and incoming carry
  function automatic logic cell_sum(input logic p, input logic c);
    return p ^ c;
  endfunction

  // carry out of a one-bit cell
  function automatic logic cell_carry(input logic g, input logic p, input logic c);
    return g | (p & c);
  endfunction

endpackage

// File: rtl/csa_bit_cell.sv
module csa_bit_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  import csa_pkg::*;

  logic g_w;
  logic p_w;

  assign g_w = pg_gen(x, y);
  assign p_w = pg_prop(x, y);
  assign s   = cell_sum(p_w, ci);
  assign co  = cell_carry(g_w, p_w, ci);
endmodule

// File: rtl/csa_ripple_block.sv
module csa_ripple_block #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] chain;

  assign chain[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_cell
    csa_bit_cell u_cell (
      .x  (x[i]),
      .y  (y[i]),
      .ci (chain[i]),
      .s  (s[i]),
      .co (chain[i+1])
    );
  end

  assign co = chain[W];
endmodule

// File: rtl/csa_select_group.sv
module csa_select_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sel,
  output logic [W-1:0] s,
  output logic         co,
  output logic [W-1:0] alt0_s,
  output logic         alt0_co,
  output logic [W-1:0] alt1_s,
  output logic         alt1_co
);
  // rail tied to carry-in 0
  csa_ripple_block #(.W(W)) u_rail0 (
    .x  (x),
    .y  (y),
    .ci (1'b0),
    .s  (alt0_s),
    .co (alt0_co)
  );

  // rail tied to carry-in 1
  csa_ripple_block #(.W(W)) u_rail1 (
    .x  (x),
    .y  (y),
    .ci (1'b1),
    .s  (alt1_s),
    .co (alt1_co)
  );

  // late-arriving carry only steers the output
  always_comb begin
    if (sel) begin
      s  = alt1_s;
      co = alt1_co;
    end else begin
      s  = alt0_s;
      co = alt0_co;
    end
  end
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NGRP = WIDTH / GROUP;

  if (WIDTH % GROUP != 0) begin : g_bad_split
    $error("csa_adder: WIDTH must be a multiple of GROUP");
  end

  // named internal events, observed by the bound checker
  logic [NGRP:0]    grp_carry;
  logic [WIDTH-1:0] rail0_sum;
  logic [WIDTH-1:0] rail1_sum;
  logic [NGRP-1:0]  rail0_co;
  logic [NGRP-1:0]  rail1_co;

  assign grp_carry[0] = cin;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    localparam int LO = gi * GROUP;
    if (gi == 0) begin : g_base
      logic [GROUP-1:0] s_w;
      logic             co_w;
      csa_ripple_block #(.W(GROUP)) u_base (
        .x  (a[LO +: GROUP]),
        .y  (b[LO +: GROUP]),
        .ci (grp_carry[0]),
        .s  (s_w),
        .co (co_w)
      );
      assign sum[LO +: GROUP]       = s_w;
      assign grp_carry[1]           = co_w;
      assign rail0_sum[LO +: GROUP] = s_w;
      assign rail1_sum[LO +: GROUP] = s_w;
      assign rail0_co[0]            = co_w;
      assign rail1_co[0]            = co_w;
    end else begin : g_sel
      csa_select_group #(.W(GROUP)) u_sel (
        .x       (a[LO +: GROUP]),
        .y       (b[LO +: GROUP]),
        .sel     (grp_carry[gi]),
        .s       (sum[LO +: GROUP]),
        .co      (grp_carry[gi+1]),
        .alt0_s  (rail0_sum[LO +: GROUP]),
        .alt0_co (rail0_co[gi]),
        .alt1_s  (rail1_sum[LO +: GROUP]),
        .alt1_co (rail1_co[gi])
      );
    end
  end

  assign cout = grp_carry[NGRP];
endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input logic [WIDTH-1:0]       a,
  input logic [WIDTH-1:0]       b,
  input logic                   cin,
  input logic [WIDTH-1:0]       sum,
  input logic                   cout,
  input logic [WIDTH/GROUP:0]   grp_carry,
  input logic [WIDTH-1:0]       rail0_sum,
  input logic [WIDTH-1:0]       rail1_sum,
  input logic [WIDTH/GROUP-1:0] rail0_co,
  input logic [WIDTH/GROUP-1:0] rail1_co
);
  localparam int NGRP = WIDTH / GROUP;

  logic [WIDTH:0] full_w;
  assign full_w = {1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin);

  // R1 / R8: whole result is the exact sum
  always_comb begin
    p_exact_sum_r1: assert ({cout, sum} == full_w)
      else $error("p_exact_sum_r1: %h + %h + %b -> %h", a, b, cin, {cout, sum});
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    localparam int HI = (g + 1) * GROUP - 1;
    localparam int LO = g * GROUP;
    logic [HI+1:0] pre_w;
    assign pre_w = {1'b0, a[HI:0]} + {1'b0, b[HI:0]} + (HI+2)'(cin);

    // R6: each group boundary carry equals the exact prefix carry
    always_comb begin
      p_prefix_carry_r6: assert (grp_carry[g+1] == pre_w[HI+1])
        else $error("p_prefix_carry_r6: group %0d", g);
    end

    if (g > 0) begin : g_upper
      logic [GROUP:0] r0_w;
      logic [GROUP:0] r1_w;
      logic [GROUP:0] plain_w;
      assign r0_w    = {rail0_co[g], rail0_sum[LO +: GROUP]};
      assign r1_w    = {rail1_co[g], rail1_sum[LO +: GROUP]};
      assign plain_w = {1'b0, a[LO +: GROUP]} + {1'b0, b[LO +: GROUP]};

      // R4: carry-in-1 rail is the carry-in-0 rail plus one
      always_comb begin
        p_rail_pair_r4: assert (r1_w == r0_w + (GROUP+1)'(1))
          else $error("p_rail_pair_r4: group %0d", g);
      end

      // R4: a carry from rail 0 implies a carry from rail 1
      always_comb begin
        p_rail_order_r4: assert (!rail0_co[g] || rail1_co[g])
          else $error("p_rail_order_r4: group %0d", g);
      end

      // R5: no incoming carry means the plain slice sum is driven out
      always_comb begin
        if (!grp_carry[g]) begin
          p_no_carry_slice_r5: assert (sum[LO +: GROUP] == plain_w[GROUP-1:0])
            else $error("p_no_carry_slice_r5: group %0d", g);
        end
      end
    end
  end
endmodule

bind csa_adder csa_adder_chk #(.WIDTH(WIDTH), .GROUP(GROUP)) u_chk (
  .a         (a),
  .b         (b),
  .cin       (cin),
  .sum       (sum),
  .cout      (cout),
  .grp_carry (grp_carry),
  .rail0_sum (rail0_sum),
  .rail1_sum (rail1_sum),
  .rail0_co  (rail0_co),
  .rail1_co  (rail1_co)
);

// File: tb/sim_csa_adder.sv
module sim_csa_adder;
  typedef struct {
    logic [32:0] exp;
    logic [31:0] x;
    logic [31:0] y;
    logic        c;
    string       req;
  } item_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  // wide instance: 32 bits, groups of 4
  logic [31:0] a0 = '0, b0 = '0, s0;
  logic        c0 = 1'b0, co0;
  csa_adder #(.WIDTH(32), .GROUP(4)) u0 (
    .a(a0), .b(b0), .cin(c0), .sum(s0), .cout(co0));

  // narrow instance: 6 bits, groups of 2
  logic [5:0] a1 = '0, b1 = '0, s1;
  logic       c1 = 1'b0, co1;
  csa_adder #(.WIDTH(6), .GROUP(2)) u1 (
    .a(a1), .b(b1), .cin(c1), .sum(s1), .cout(co1));

  item_t q_wide[$];
  item_t q_narrow[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic drive_wide(input logic [31:0] x, input logic [31:0] y,
                            input logic c, input string req);
    item_t it;
    @(posedge clk);
    #1;
    a0 = x; b0 = y; c0 = c;
    it.exp = {1'b0, x} + {1'b0, y} + 33'(c);
    it.x = x; it.y = y; it.c = c; it.req = req;
    q_wide.push_back(it);
  endtask

  task automatic drive_narrow(input logic [5:0] x, input logic [5:0] y,
                              input logic c, input string req);
    item_t it;
    @(posedge clk);
    #1;
    a1 = x; b1 = y; c1 = c;
    it.exp = 33'({1'b0, x} + {1'b0, y} + 7'(c));
    it.x = 32'(x); it.y = 32'(y); it.c = c; it.req = req;
    q_narrow.push_back(it);
  endtask

  // monitor: compare away from the driving edge
  always @(negedge clk) begin
    if (q_wide.size() > 0) begin
      item_t it;
      it = q_wide.pop_front();
      n_vec++;
      if ({co0, s0} !== it.exp) begin
        n_bad++;
        $display("FAIL %s wide %h+%h+%b: got %h expected %h",
                 it.req, it.x, it.y, it.c, {co0, s0}, it.exp);
      end
    end
    if (q_narrow.size() > 0) begin
      item_t it;
      it = q_narrow.pop_front();
      n_vec++;
      if ({co1, s1} !== it.exp[6:0]) begin
        n_bad++;
        $display("FAIL %s narrow %h+%h+%b: got %h expected %h",
                 it.req, it.x[5:0], it.y[5:0], it.c, {co1, s1}, it.exp[6:0]);
      end
    end
  end

  initial begin
    // R7: all-zero inputs, then a pure generate at the top bit
    drive_wide(32'h0, 32'h0, 1'b0, "R7");
    drive_wide(32'h8000_0000, 32'h8000_0000, 1'b0, "R7");
    // R3: lowest group takes the external carry directly
    drive_wide(32'h0, 32'h0, 1'b1, "R3");
    // R2: carry ripples from bit 0 through every group
    drive_wide(32'hFFFF_FFFF, 32'h0, 1'b1, "R2");
    drive_wide(32'h0, 32'hFFFF_FFFF, 1'b1, "R2");
    drive_wide(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R2");
    // R4: carry out of the lowest group selects rail 1 above
    drive_wide(32'h0000_000F, 32'h0000_0001, 1'b0, "R4");
    // R5: no carry enters any upper group
    drive_wide(32'h1234_0000, 32'h0000_5678, 1'b0, "R5");
    // R6: carry crosses two group boundaries
    drive_wide(32'h0000_00FF, 32'h0000_0001, 1'b0, "R6");
    drive_wide(32'h7FFF_FFFF, 32'h0000_0000, 1'b1, "R6");
    // R1: exhaustive sweep of the narrow instance
    for (int i = 0; i < 8192; i++)
      drive_narrow(i[5:0], i[11:6], i[12], "R1");
    // R8: random wide operands
    for (int k = 0; k < 3000; k++)
      drive_wide($urandom, $urandom, 1'($urandom), "R8");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule